// File: doc/BRIEF.md
# Command/Response Buffer Control Front End

This block is the host-facing register front end of a security coprocessor that is driven through a shared command/response buffer. A host writes a command image into a byte-addressable data buffer. It claims or gives up locality ownership and moves the device between its idle and ready states. It then starts the command. The start raises a one-cycle request toward a command engine, carrying the command length clamped to the buffer capacity. The engine answers with a completion handshake. That handshake clears the in-flight bit and can flag a sticky fatal error. A cancel is passed on to the engine only while a command is in flight.

The address space is split into 4 KiB windows, one per locality. Within a window, offsets below 0x80 hold control registers and offsets from 0x80 upward form the data buffer. Writes carry a byte count of 1 to 4 (`bus_size` = count - 1) and are little-endian. Reads return the stored contents one cycle after the read strobe.

Top module: `cmdrsp_buf_ctrl`

## Requirements
- R1: The access locality is `bus_addr[15:12]`; only offsets `bus_addr[11:0]` select a register or buffer byte, and a start is accepted only when that locality equals the stored owner locality (reset value 0) while ownership is claimed.
- R2: A write at window offset 0x80 or above stores `bus_size+1` bytes little-endian (byte k from `bus_wdata[8k+7:8k]`) at buffer index offset-0x80+k, dropping bytes past the 64-byte buffer. A read at such an offset returns four bytes starting there, with bytes past the buffer reading 0.
- R3: A write of 1 to the control request register (0x040) clears the idle bit (bit 1 of status register 0x044), a write of 2 sets it, and any other value leaves it unchanged.
- R4: A write of 1 to locality control (0x008) sets granted (bit 0 of 0x00C), clears been-seized (bit 1 of 0x00C) and sets owned (bit 1 of 0x000). A write of 2 clears owned and granted. A write of 8 or any other value changes nothing.
- R5: A write to the start register (0x04C) is accepted only if the value is 1, start bit 0 is clear and R1 holds. Acceptance sets start bit 0 and pulses `eng_req_valid` high for exactly one cycle, in the cycle after the write edge.
- R6: `eng_req_len` during the pulse equals the smaller of the big-endian 32-bit length in buffer bytes 2..5 and the buffer size (64).
- R7: A write of 1 to the cancel register (0x048) pulses `eng_cancel` for one cycle only if start bit 0 is set at that write. Other values, or a cancel with no command in flight, give no pulse.
- R8: `eng_done` clears start bit 0. A nonzero `eng_status` with `eng_done` sets the sticky fatal bit (bit 0 of 0x044).
- R9: After reset, 0x000 reads 0x81 (valid bit 7, established bit 0), 0x044 reads 0x2, 0x04C and 0x00C read 0, and the size registers (0x058, 0x064) read 64. The command and response address pairs (0x05C/0x060, 0x068/0x06C) read BASE_ADDR+0x80, split into low and high words.
- R10: Identification word 0x030 reads interface type 1 in [1:0], version 1 in [7:4], multi-locality 0 in bit 8, fast idle bypass 1 in bit 9, transfer size code 3 (64 bytes) in [12:11], FIFO support 0 in bit 13, buffer interface support 1 in bit 14, selector 1 in [18:17] and revision 0 in [27:24]. Word 0x034 reads VENDOR_ID in [15:0].
- R11: Writes to identification, size, address and status registers have no effect on their read values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | Byte address; [15:12] locality, [11:0] offset |
| bus_size | input | 2 | Byte count minus one for writes |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| eng_req_valid | output | 1 | One-cycle command request pulse |
| eng_req_len | output | 7 | Clamped command length |
| eng_cancel | output | 1 | One-cycle cancel pulse |
| eng_done | input | 1 | Command completion |
| eng_status | input | 8 | Completion status, nonzero is fatal |

## Verification
The cancel write and the engine completion can land on the same clock edge. The cancel must still be forwarded, because the start bit is set when the write is sampled, and the start bit must still end clear. The bench provokes this by driving the cancel write and `eng_done` in the same cycle. It then checks `eng_cancel` after that edge and reads back the start register. A start write in the cycle of a completion is also judged against the old start bit and must be refused.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  localparam logic [11:0] OFF_LOC_STATE = 12'h000;
  localparam logic [11:0] OFF_LOC_CTRL  = 12'h008;
  localparam logic [11:0] OFF_LOC_STS   = 12'h00C;
  localparam logic [11:0] OFF_ID0       = 12'h030;
  localparam logic [11:0] OFF_ID1       = 12'h034;
  localparam logic [11:0] OFF_CTRL_REQ  = 12'h040;
  localparam logic [11:0] OFF_CTRL_STS  = 12'h044;
  localparam logic [11:0] OFF_CANCEL    = 12'h048;
  localparam logic [11:0] OFF_START     = 12'h04C;
  localparam logic [11:0] OFF_CMD_SIZE  = 12'h058;
  localparam logic [11:0] OFF_CMD_LO    = 12'h05C;
  localparam logic [11:0] OFF_CMD_HI    = 12'h060;
  localparam logic [11:0] OFF_RSP_SIZE  = 12'h064;
  localparam logic [11:0] OFF_RSP_LO    = 12'h068;
  localparam logic [11:0] OFF_RSP_HI    = 12'h06C;
  localparam logic [11:0] OFF_BUF       = 12'h080;

  localparam logic [31:0] VAL_INVOKE  = 32'd1;
  localparam logic [31:0] VAL_READY   = 32'd1;
  localparam logic [31:0] VAL_IDLE    = 32'd2;
  localparam logic [31:0] VAL_CLAIM   = 32'd1;
  localparam logic [31:0] VAL_RELEASE = 32'd2;

  // Keep only the bytes an access of (sz+1) bytes carries.
  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      2'd2:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] clamp_len(input logic [31:0] hdr, input logic [31:0] cap);
    return (hdr > cap) ? cap : hdr;
  endfunction

  function automatic logic [31:0] id_word0();
    logic [31:0] w;
    w        = '0;
    w[1:0]   = 2'd1;  // active buffer interface
    w[7:4]   = 4'd1;  // interface version
    w[8]     = 1'b0;  // locality 0 only
    w[9]     = 1'b1;  // fast idle bypass
    w[12:11] = 2'd3;  // 64-byte transfers
    w[13]    = 1'b0;  // no FIFO
    w[14]    = 1'b1;  // buffer interface supported
    w[18:17] = 2'd1;  // selector
    w[27:24] = 4'd0;  // revision
    return w;
  endfunction

endpackage

// File: rtl/cbuf_buffer.sv
module cbuf_buffer #(
  parameter int BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [11:0] wr_idx,
  input  logic [2:0]  nbytes,
  input  logic [31:0] wdata,
  input  logic [11:0] rd_idx,
  output logic [31:0] rd_word,
  output logic [31:0] hdr_len
);
  logic [8*BYTES-1:0] flat;

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    logic [11:0] rel;
    logic        hit;
    logic [7:0]  q;
    assign rel = 12'(i) - wr_idx;
    assign hit = we && (wr_idx <= 12'(i)) && (rel < {9'd0, nbytes});
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata[{rel[1:0], 3'b000} +: 8];
    end
    assign flat[8*i +: 8] = q;
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < BYTES; j++) begin
        if (rd_idx + 12'(k) == 12'(j)) rd_word[8*k +: 8] = flat[8*j +: 8];
      end
    end
  end

  // Big-endian length field at bytes 2..5 of the command header.
  assign hdr_len = {flat[8*2 +: 8], flat[8*3 +: 8], flat[8*4 +: 8], flat[8*5 +: 8]};
endmodule

// File: rtl/cbuf_locality.sv
module cbuf_locality #(
  parameter int LOC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim_ev,
  input  logic             release_ev,
  output logic             owned,
  output logic             granted,
  output logic             seized,
  output logic [LOC_W-1:0] owner_loc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owned     <= 1'b0;
      granted   <= 1'b0;
      seized    <= 1'b0;
      owner_loc <= '0;
    end else if (claim_ev) begin
      owned   <= 1'b1;
      granted <= 1'b1;
      seized  <= 1'b0;
    end else if (release_ev) begin
      owned   <= 1'b0;
      granted <= 1'b0;
    end
  end
endmodule

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl #(
  parameter int BYTES = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_ev,
  input  logic             idle_ev,
  input  logic             start_ev,
  input  logic             cancel_ev,
  input  logic             done,
  input  logic             done_err,
  input  logic [31:0]      hdr_len,
  output logic             idle,
  output logic             fatal,
  output logic             invoke,
  output logic             start_acc,
  output logic             cancel_fwd,
  output logic             req_valid,
  output logic [LEN_W-1:0] req_len,
  output logic             cancel_out
);
  import cbuf_pkg::*;

  assign start_acc  = start_ev && !invoke;
  assign cancel_fwd = cancel_ev && invoke;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle       <= 1'b1;
      fatal      <= 1'b0;
      invoke     <= 1'b0;
      req_valid  <= 1'b0;
      req_len    <= '0;
      cancel_out <= 1'b0;
    end else begin
      if (ready_ev)     idle <= 1'b0;
      else if (idle_ev) idle <= 1'b1;
      if (done && done_err) fatal <= 1'b1;
      if (start_acc)    invoke <= 1'b1;
      else if (done)    invoke <= 1'b0;
      req_valid  <= start_acc;
      cancel_out <= cancel_fwd;
      if (start_acc) req_len <= LEN_W'(clamp_len(hdr_len, 32'(BYTES)));
    end
  end
endmodule

// File: rtl/cmdrsp_buf_ctrl.sv
module cmdrsp_buf_ctrl #(
  parameter int          ADDR_W    = 16,
  parameter int          BUF_BYTES = 64,
  parameter logic [63:0] BASE_ADDR = 64'h0000_0000_FED4_0000,
  parameter logic [15:0] VENDOR_ID = 16'h1D5A,
  localparam int         LOC_W     = ADDR_W - 12,
  localparam int         LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_req_valid,
  output logic [LEN_W-1:0]  eng_req_len,
  output logic              eng_cancel,
  input  logic              eng_done,
  input  logic [7:0]        eng_status
);
  import cbuf_pkg::*;

  localparam logic [63:0] BUF_ADDR = BASE_ADDR + 64'(OFF_BUF);

  logic [11:0]      off;
  logic [LOC_W-1:0] acc_loc;
  logic [31:0]      wval;
  logic             in_buf, reg_wr;
  assign off     = bus_addr[11:0];
  assign acc_loc = bus_addr[ADDR_W-1:12];
  assign wval    = bus_wdata & size_mask(bus_size);
  assign in_buf  = off >= OFF_BUF;
  assign reg_wr  = bus_wr && !in_buf;

  // Named events, also observed by the checker.
  logic ev_ready, ev_idle, ev_start, ev_cancel, ev_claim, ev_release, loc_match;
  logic             owned, granted, seized;
  logic [LOC_W-1:0] owner_loc;
  assign ev_ready   = reg_wr && off == OFF_CTRL_REQ && wval == VAL_READY;
  assign ev_idle    = reg_wr && off == OFF_CTRL_REQ && wval == VAL_IDLE;
  assign ev_claim   = reg_wr && off == OFF_LOC_CTRL && wval == VAL_CLAIM;
  assign ev_release = reg_wr && off == OFF_LOC_CTRL && wval == VAL_RELEASE;
  assign loc_match  = owned && owner_loc == acc_loc;
  assign ev_start   = reg_wr && off == OFF_START && wval == VAL_INVOKE && loc_match;
  assign ev_cancel  = reg_wr && off == OFF_CANCEL && wval == VAL_INVOKE;

  cbuf_locality #(.LOC_W(LOC_W)) loc_i (
    .clk(clk), .rst_n(rst_n), .claim_ev(ev_claim), .release_ev(ev_release),
    .owned(owned), .granted(granted), .seized(seized), .owner_loc(owner_loc)
  );

  logic [31:0] buf_word, hdr_len;
  cbuf_buffer #(.BYTES(BUF_BYTES)) buf_i (
    .clk(clk), .rst_n(rst_n), .we(bus_wr && in_buf), .wr_idx(off - OFF_BUF),
    .nbytes({1'b0, bus_size} + 3'd1), .wdata(bus_wdata), .rd_idx(off - OFF_BUF),
    .rd_word(buf_word), .hdr_len(hdr_len)
  );

  logic idle, fatal, invoke, start_acc, cancel_fwd;
  cbuf_ctrl #(.BYTES(BUF_BYTES), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ready_ev(ev_ready), .idle_ev(ev_idle),
    .start_ev(ev_start), .cancel_ev(ev_cancel), .done(eng_done),
    .done_err(eng_status != 8'd0), .hdr_len(hdr_len), .idle(idle), .fatal(fatal),
    .invoke(invoke), .start_acc(start_acc), .cancel_fwd(cancel_fwd),
    .req_valid(eng_req_valid), .req_len(eng_req_len), .cancel_out(eng_cancel)
  );

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_buf) rd_mux = buf_word;
    else begin
      case (off)
        OFF_LOC_STATE: rd_mux = {24'd0, 1'b1, 1'b0, 4'(owner_loc), owned, 1'b1};
        OFF_LOC_STS:   rd_mux = {30'd0, seized, granted};
        OFF_ID0:       rd_mux = id_word0();
        OFF_ID1:       rd_mux = {16'd0, VENDOR_ID};
        OFF_CTRL_STS:  rd_mux = {30'd0, idle, fatal};
        OFF_START:     rd_mux = {31'd0, invoke};
        OFF_CMD_SIZE,
        OFF_RSP_SIZE:  rd_mux = 32'(BUF_BYTES);
        OFF_CMD_LO,
        OFF_RSP_LO:    rd_mux = BUF_ADDR[31:0];
        OFF_CMD_HI,
        OFF_RSP_HI:    rd_mux = BUF_ADDR[63:32];
        default:       rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/cbuf_checker.sv
module cbuf_checker #(
  parameter int BYTES = 64,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LEN_W-1:0] req_len,
  input logic             cancel_out,
  input logic             cancel_fwd,
  input logic             invoke,
  input logic             done,
  input logic             fatal,
  input logic             ev_ready,
  input logic             idle,
  input logic             start_acc
);
  AST_READY_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |=> !idle); // R3
  AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R5
  AST_START_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (req_valid && invoke)); // R5
  AST_REQ_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (32'(req_len) <= 32'(BYTES))); // R6
  AST_CANCEL_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_fwd |=> (cancel_out && $past(invoke))); // R7
  AST_DONE_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invoke) |=> !invoke); // R8
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal); // R8
endmodule

bind cmdrsp_buf_ctrl cbuf_checker #(.BYTES(BUF_BYTES), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(eng_req_valid), .req_len(eng_req_len),
  .cancel_out(eng_cancel), .cancel_fwd(cancel_fwd), .invoke(invoke),
  .done(eng_done), .fatal(fatal), .ev_ready(ev_ready), .idle(idle),
  .start_acc(start_acc)
);

// File: tb/cmdrsp_buf_ctrl_tb_top.sv
module cmdrsp_buf_ctrl_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, bus_wr, bus_rd, eng_done, eng_req_valid, eng_cancel;
  logic [15:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic [6:0]  eng_req_len;
  logic [7:0]  eng_status;

  cmdrsp_buf_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_req_valid(eng_req_valid), .eng_req_len(eng_req_len), .eng_cancel(eng_cancel),
    .eng_done(eng_done), .eng_status(eng_status)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [64];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic complete(input logic [7:0] st);
    @(negedge clk);
    eng_done = 1'b1; eng_status = st;
    @(posedge clk);
    @(negedge clk);
    eng_done = 1'b0; eng_status = 8'd0;
  endtask

  task automatic set_hdr(input logic [31:0] l);
    wr(16'h0082, 2'd3, {l[7:0], l[15:8], l[23:16], l[31:24]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, exp, id0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_size = '0;
    bus_wdata = '0; eng_done = 1'b0; eng_status = '0;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset state
    chk("R9 no request", {31'd0, eng_req_valid}, 32'd0);
    rd(16'h0000, r); chk("R9 loc state", r, 32'h81);
    rd(16'h0044, r); chk("R9 ctrl sts", r, 32'h2);
    rd(16'h004C, r); chk("R9 start", r, 32'h0);
    rd(16'h000C, r); chk("R9 loc sts", r, 32'h0);
    rd(16'h0058, r); chk("R9 cmd size", r, 32'd64);
    rd(16'h0064, r); chk("R9 rsp size", r, 32'd64);
    rd(16'h005C, r); chk("R9 cmd lo", r, 32'hFED4_0080);
    rd(16'h0060, r); chk("R9 cmd hi", r, 32'h0);
    rd(16'h0068, r); chk("R9 rsp lo", r, 32'hFED4_0080);
    rd(16'h006C, r); chk("R9 rsp hi", r, 32'h0);

    // R10 identification
    id0 = 32'd1 | (32'd1 << 4) | (32'd1 << 9) | (32'd3 << 11) | (32'd1 << 14) | (32'd1 << 17);
    rd(16'h0030, r); chk("R10 id0", r, id0);
    rd(16'h0034, r); chk("R10 id1", r, 32'h1D5A);

    // R11 read-only registers
    wr(16'h0030, 2'd3, 32'hFFFF_FFFF);
    wr(16'h0058, 2'd3, 32'h0000_0003);
    wr(16'h005C, 2'd3, 32'h1234_5678);
    wr(16'h000C, 2'd3, 32'hFFFF_FFFF);
    wr(16'h0044, 2'd3, 32'h0000_0001);
    rd(16'h0030, r); chk("R11 id0", r, id0);
    rd(16'h0058, r); chk("R11 cmd size", r, 32'd64);
    rd(16'h005C, r); chk("R11 cmd lo", r, 32'hFED4_0080);
    rd(16'h000C, r); chk("R11 loc sts", r, 32'h0);
    rd(16'h0044, r); chk("R11 ctrl sts", r, 32'h2);

    // R2 + R1 buffer sweep over every offset and size, rotating localities
    for (int o = 0; o < 64; o++) begin
      for (int s = 0; s < 4; s++) begin
        logic [31:0] d;
        d = {8'(o + 3 * s + 1), 8'(o * 5 + s), 8'(o ^ 8'hA5), 8'(o * 7 + s * 31)};
        wr({4'(o + s), 12'(12'h080 + o)}, 2'(s), d);
        for (int k = 0; k <= s; k++)
          if (o + k < 64) model[o + k] = d[8 * k +: 8];
      end
    end
    for (int o = 0; o < 64; o++) begin
      exp = '0;
      for (int k = 0; k < 4; k++)
        if (o + k < 64) exp[8 * k +: 8] = model[o + k];
      rd({4'(o), 12'(12'h080 + o)}, r);
      chk($sformatf("R2 buffer off %0d", o), r, exp);
    end

    // R3 control request value sweep
    for (int v = 0; v < 8; v++) begin
      logic [31:0] st;
      wr(16'h0040, 2'd0, 32'd2);
      wr(16'h0040, 2'd0, 32'd1);
      wr(16'h0040, 2'd0, 32'(v));
      st = (v == 2) ? 32'h2 : 32'h0;
      rd(16'h0044, r); chk($sformatf("R3 req value %0d", v), r, st);
    end
    wr(16'h0040, 2'd0, 32'd2);
    rd(16'h0044, r); chk("R3 go idle", r, 32'h2);

    // R4 locality; start refused while unowned (R1)
    set_hdr(32'd20);
    wr(16'h004C, 2'd3, 32'd1);
    chk("R1 start unowned", {31'd0, eng_req_valid}, 32'd0);
    wr(16'h0008, 2'd3, 32'd1);
    rd(16'h0000, r); chk("R4 claim state", r, 32'h83);
    rd(16'h000C, r); chk("R4 claim sts", r, 32'h1);
    wr(16'h0008, 2'd3, 32'd8);
    rd(16'h0000, r); chk("R4 establish ignored", r, 32'h83);
    wr(16'h0008, 2'd3, 32'd2);
    rd(16'h0000, r); chk("R4 release state", r, 32'h81);
    rd(16'h000C, r); chk("R4 release sts", r, 32'h0);
    wr(16'h0008, 2'd3, 32'd1);

    // R1 other localities and R5 wrong values are refused
    for (int l = 1; l < 16; l++) begin
      wr({4'(l), 12'h04C}, 2'd3, 32'd1);
      chk($sformatf("R1 start loc %0d", l), {31'd0, eng_req_valid}, 32'd0);
    end
    wr(16'h004C, 2'd3, 32'd3);
    chk("R5 start value 3", {31'd0, eng_req_valid}, 32'd0);
    rd(16'h004C, r); chk("R5 start bit clear", r, 32'h0);

    // R7 cancel with nothing in flight
    wr(16'h0048, 2'd3, 32'd1);
    chk("R7 idle cancel", {31'd0, eng_cancel}, 32'd0);

    // R5 accepted start, single pulse, R6 length
    wr(16'h004C, 2'd0, 32'd1);
    chk("R5 req pulse", {31'd0, eng_req_valid}, 32'd1);
    chk("R6 len 20", {25'd0, eng_req_len}, 32'd20);
    @(negedge clk);
    chk("R5 pulse ends", {31'd0, eng_req_valid}, 32'd0);
    rd(16'h004C, r); chk("R5 start bit set", r, 32'h1);
    wr(16'h004C, 2'd3, 32'd1);
    chk("R5 restart refused", {31'd0, eng_req_valid}, 32'd0);

    // R7 cancel values while in flight
    wr(16'h0048, 2'd3, 32'd2);
    chk("R7 cancel value 2", {31'd0, eng_cancel}, 32'd0);
    wr(16'h0048, 2'd3, 32'd1);
    chk("R7 cancel fwd", {31'd0, eng_cancel}, 32'd1);

    // R8 good completion
    complete(8'd0);
    rd(16'h004C, r); chk("R8 start cleared", r, 32'h0);
    rd(16'h0044, r); chk("R8 no fatal", r, 32'h2);

    // R6 clamp sweep
    begin
      logic [31:0] lens [6];
      lens = '{32'd0, 32'd10, 32'd64, 32'd65, 32'd1000, 32'h0100_0000};
      for (int i = 0; i < 6; i++) begin
        set_hdr(lens[i]);
        wr(16'h004C, 2'd3, 32'd1);
        chk($sformatf("R6 req hdr %0d", lens[i]), {31'd0, eng_req_valid}, 32'd1);
        chk($sformatf("R6 len hdr %0d", lens[i]), {25'd0, eng_req_len},
            (lens[i] > 32'd64) ? 32'd64 : lens[i]);
        complete(8'd0);
      end
    end

    // Same cycle: cancel write and completion (R7, R8)
    wr(16'h004C, 2'd3, 32'd1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 16'h0048; bus_size = 2'd3; bus_wdata = 32'd1;
    eng_done = 1'b1; eng_status = 8'd0;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; eng_done = 1'b0;
    chk("R7 cancel with done", {31'd0, eng_cancel}, 32'd1);
    rd(16'h004C, r); chk("R8 cleared with cancel", r, 32'h0);

    // Same cycle: start write and completion, start judged on old bit (R5)
    wr(16'h004C, 2'd3, 32'd1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 16'h004C; bus_size = 2'd3; bus_wdata = 32'd1;
    eng_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; eng_done = 1'b0;
    chk("R5 start with done refused", {31'd0, eng_req_valid}, 32'd0);
    rd(16'h004C, r); chk("R5 bit after done", r, 32'h0);

    // R8 fatal completion, sticky
    wr(16'h004C, 2'd3, 32'd1);
    complete(8'd5);
    rd(16'h0044, r); chk("R8 fatal set", r, 32'h3);
    wr(16'h004C, 2'd3, 32'd1);
    complete(8'd0);
    rd(16'h0044, r); chk("R8 fatal sticky", r, 32'h3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule